// File: doc/BRIEF.md
# Byte-to-Word Dual-Clock FIFO

This block moves a byte stream from one clock domain into a second, unrelated clock domain and hands it out as 32-bit words. The producer pushes one byte per write-clock cycle while the FIFO has room. Every four consecutive bytes are gathered into one word, and a word is placed in storage only when its last byte arrives. The consumer sees the oldest complete word on the read data port as soon as it exists. Pulsing the read request consumes that word, and the following word appears on the next read-clock edge.

Each side has its own fill count and flag. The write side counts bytes, including the bytes of a group that is not yet complete, and raises full at 2048. The read side counts complete words and raises empty at zero. Pointers cross the boundary in reflected binary (Gray) code through register chains. A count can lag behind the true fill level, but it never reports room or data that its own side may not safely use. A write request while full and a read request while empty are both dropped. The block has one asynchronous active-low reset for both domains. The write request and write byte are taken to be synchronous to the write clock.

Top module: `bytepack_async_fifo`

## Requirements
- R1: Bytes are packed in write order. The first byte of each group of four lands in `rd_word[7:0]`, the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R2: Whenever `rd_empty` is low, `rd_word` already holds the oldest unread word with `rd_req` low. A read-clock edge with `rd_req` high and `rd_empty` low retires that word, and the next word is shown after that edge.
- R3: A write request while `wr_full` is high is dropped. `wr_used` stays the same, and the dropped byte never appears in the read data.
- R4: A read request while `rd_empty` is high is dropped. `rd_used` never exceeds 512, so it never wraps below zero.
- R5: Capacity is 2048 bytes (512 words). With no reads, `wr_full` rises in the write-clock cycle in which `wr_used` reaches 2048.
- R6: Bytes of an incomplete group are not visible on the read side. With one to three bytes pending, `rd_used` stays 0 and `rd_empty` stays high.
- R7: `wr_used` equals four times the stored words plus the pending bytes. Once the other side has been idle for a few cycles, both counts are exact.
- R8: The pointer copies sent across the boundary change in at most one bit per clock edge of their own domain.
- R9: While reset is held, `wr_full` is 0, `wr_used` is 0, `rd_empty` is 1 and `rd_used` is 0.
- R10: Under free-running unrelated clocks and random bursts on both sides, every word read matches the bytes written, in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| arst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_req | input | 1 | Push `wr_byte` on this write-clock edge |
| wr_byte | input | 8 | Byte to push |
| wr_full | output | 1 | No room for another byte |
| wr_used | output | 12 | Bytes held, as seen by the write side |
| rd_req | input | 1 | Retire the word shown on `rd_word` |
| rd_word | output | 32 | Oldest complete word (show-ahead) |
| rd_empty | output | 1 | No complete word to read |
| rd_used | output | 10 | Complete words held, as seen by the read side |

## Verification
The hardest condition to reach is the full boundary while the read clock keeps running. Here the write side must stop on a delayed copy of the read pointer, and a dropped write must leave no trace in the word stream. The stress run alternates long phases in which the reader stops entirely with phases in which it drains quickly. During the stop phases the writer fills the FIFO and keeps asserting the request while full. During the drain phases the reader keeps issuing requests against an empty FIFO. A directed sequence also fills all 2048 bytes, pushes one extra byte, and drains 512 words against a computed pattern.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int PTR_MAX = 16;

    function automatic logic [PTR_MAX-1:0] b2g(input logic [PTR_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_MAX-1:0] g2b(input logic [PTR_MAX-1:0] g);
        logic [PTR_MAX-1:0] b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [STAGES-1:0][W-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bp_wr_ctrl.sv
module bp_wr_ctrl
    import bp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int WORDS  = 512,
    localparam int AW     = $clog2(WORDS),
    localparam int PW     = AW + 1,
    localparam int LW     = $clog2(LANES),
    localparam int WORD_W = BYTE_W * LANES,
    localparam int BYTES  = WORDS * LANES,
    localparam int UW     = $clog2(BYTES + 1)
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              req,
    input  logic [BYTE_W-1:0] din,
    input  logic [PW-1:0]     rgray_s,
    output logic              full,
    output logic [UW-1:0]     used,
    output logic              commit,
    output logic [AW-1:0]     waddr,
    output logic [WORD_W-1:0] wword,
    output logic [PW-1:0]     wgray
);
    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic [LW-1:0]     lane;
        logic [WORD_W-1:0] pack;
    } wst_t;

    wst_t s_q, s_d;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] words;
    logic          accept;

    always_comb begin
        s_d    = s_q;
        rbin_s = PW'(g2b(PTR_MAX'(rgray_s)));
        words  = s_q.bin - rbin_s;
        used   = UW'(words) * UW'(LANES) + UW'(s_q.lane);
        full   = (used == UW'(BYTES));
        accept = req && !full;
        commit = accept && (s_q.lane == LW'(LANES - 1));
        wword  = s_q.pack;
        wword[(LANES-1)*BYTE_W +: BYTE_W] = din;
        if (accept) begin
            s_d.pack[s_q.lane*BYTE_W +: BYTE_W] = din;
            if (commit) begin
                s_d.lane = '0;
                s_d.bin  = s_q.bin + 1'b1;
            end else begin
                s_d.lane = s_q.lane + 1'b1;
            end
        end
        s_d.gray = PW'(b2g(PTR_MAX'(s_d.bin)));
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign waddr = s_q.bin[AW-1:0];
    assign wgray = s_q.gray;

    // R3: a full FIFO leaves the write state untouched
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!arst_n)
        full |=> ($stable(s_q.bin) && $stable(s_q.lane)));

    // R5: byte count never passes capacity
    assert_used_in_range_R5: assert property (@(posedge clk) disable iff (!arst_n)
        used <= UW'(BYTES));

    // R8: outgoing pointer copy moves one bit at a time
    assert_wgray_one_step_R8: assert property (@(posedge clk) disable iff (!arst_n)
        $countones(s_q.gray ^ $past(s_q.gray)) <= 1);
endmodule

// File: rtl/bp_rd_ctrl.sv
module bp_rd_ctrl
    import bp_pkg::*;
#(
    parameter int WORDS = 512,
    localparam int AW   = $clog2(WORDS),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          req,
    input  logic [PW-1:0] wgray_s,
    output logic          empty,
    output logic [PW-1:0] used,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rst_t;

    rst_t s_q, s_d;
    logic [PW-1:0] wbin_s;
    logic          accept;

    always_comb begin
        s_d    = s_q;
        wbin_s = PW'(g2b(PTR_MAX'(wgray_s)));
        used   = wbin_s - s_q.bin;
        empty  = (used == '0);
        accept = req && !empty;
        if (accept) s_d.bin = s_q.bin + 1'b1;
        s_d.gray = PW'(b2g(PTR_MAX'(s_d.bin)));
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign raddr = s_q.bin[AW-1:0];
    assign rgray = s_q.gray;

    // R4: reading an empty FIFO does not move the read pointer
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!arst_n)
        empty |=> $stable(s_q.bin));

    // R4: word count never wraps past capacity
    assert_count_no_wrap_R4: assert property (@(posedge clk) disable iff (!arst_n)
        used <= PW'(WORDS));

    // R2: an accepted read advances by exactly one word
    assert_read_steps_one_R2: assert property (@(posedge clk) disable iff (!arst_n)
        (req && !empty) |=> (s_q.bin == $past(s_q.bin) + 1'b1));

    // R8: outgoing pointer copy moves one bit at a time
    assert_rgray_one_step_R8: assert property (@(posedge clk) disable iff (!arst_n)
        $countones(s_q.gray ^ $past(s_q.gray)) <= 1);
endmodule

// File: rtl/bytepack_async_fifo.sv
module bytepack_async_fifo #(
    parameter int BYTE_W    = 8,
    parameter int LANES     = 4,
    parameter int WORDS     = 512,
    parameter int SYNC_STGS = 2,
    localparam int AW     = $clog2(WORDS),
    localparam int PW     = AW + 1,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int UW     = $clog2(WORDS * LANES + 1)
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              arst_n,
    input  logic              wr_req,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              wr_full,
    output logic [UW-1:0]     wr_used,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_empty,
    output logic [PW-1:0]     rd_used
);
    logic              commit;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [WORD_W-1:0] wword;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [WORD_W-1:0] mem [WORDS];

    bp_wr_ctrl #(.BYTE_W(BYTE_W), .LANES(LANES), .WORDS(WORDS)) u_wr (
        .clk(wr_clk), .arst_n(arst_n), .req(wr_req), .din(wr_byte),
        .rgray_s(rgray_s), .full(wr_full), .used(wr_used), .commit(commit),
        .waddr(waddr), .wword(wword), .wgray(wgray)
    );

    bp_sync #(.W(PW), .STAGES(SYNC_STGS)) u_w2r (
        .clk(rd_clk), .arst_n(arst_n), .d(wgray), .q(wgray_s)
    );

    bp_sync #(.W(PW), .STAGES(SYNC_STGS)) u_r2w (
        .clk(wr_clk), .arst_n(arst_n), .d(rgray), .q(rgray_s)
    );

    bp_rd_ctrl #(.WORDS(WORDS)) u_rd (
        .clk(rd_clk), .arst_n(arst_n), .req(rd_req), .wgray_s(wgray_s),
        .empty(rd_empty), .used(rd_used), .raddr(raddr), .rgray(rgray)
    );

    always_ff @(posedge wr_clk) begin
        if (commit) mem[waddr] <= wword;
    end

    assign rd_word = mem[raddr];
endmodule

// File: tb/tb_bytepack_async_fifo.sv
module tb_bytepack_async_fifo;
    // one time unit = 0.1 ns: wr_clk 100 MHz, rd_clk about 172 MHz
    localparam int NW   = 25050;
    localparam int NB   = NW * 4;
    localparam int WDOG = 190000;
    // stimulus bytes in write order (first byte in bits 63:56), expected word in 31:0
    localparam logic [63:0] VEC [6] = '{
        {32'h11223344, 32'h44332211},
        {32'h00FF00FF, 32'hFF00FF00},
        {32'hA5A55A5A, 32'h5A5AA5A5},
        {32'h01020304, 32'h04030201},
        {32'hFFFFFFFF, 32'hFFFFFFFF},
        {32'h80000001, 32'h01000080}
    };

    logic        wr_clk = 0, rd_clk = 0, arst_n = 0;
    logic        wr_req = 0, rd_req = 0;
    logic [7:0]  wr_byte = 0;
    logic        wr_full, rd_empty;
    logic [11:0] wr_used;
    logic [9:0]  rd_used;
    logic [31:0] rd_word;

    int n_chk = 0, n_bad = 0, wcyc = 0;
    bit done = 0;
    logic [7:0] q [$];

    always #50 wr_clk = ~wr_clk;
    always #29 rd_clk = ~rd_clk;

    bytepack_async_fifo dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n),
        .wr_req(wr_req), .wr_byte(wr_byte), .wr_full(wr_full), .wr_used(wr_used),
        .rd_req(rd_req), .rd_word(rd_word), .rd_empty(rd_empty), .rd_used(rd_used)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge wr_clk);
        wr_req  = 1;
        wr_byte = b;
    endtask

    task automatic wr_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_req = 0;
        end
    endtask

    task automatic rd_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_req = 0;
        end
    endtask

    function automatic logic [7:0] pat(input int n);
        return 8'(n * 7 + 3);
    endfunction

    always @(posedge wr_clk) begin
        wcyc++;
        if (wcyc > WDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", wcyc, WDOG);
            finish_run();
        end
    end

    initial begin
        // R9: values while reset is held
        repeat (3) @(negedge wr_clk);
        chk("R9 wr_full", 32'(wr_full), 0);
        chk("R9 wr_used", 32'(wr_used), 0);
        chk("R9 rd_empty", 32'(rd_empty), 1);
        chk("R9 rd_used", 32'(rd_used), 0);
        arst_n = 1;
        wr_idle(3);

        // table walk: R1 packing order, R2 show-ahead without request
        for (int v = 0; v < 6; v++) begin
            for (int k = 0; k < 4; k++) push(VEC[v][63 - 8*k -: 8]);
            wr_idle(1);
            rd_idle(6);
            chk("R2 not empty", 32'(rd_empty), 0);
            chk("R1 word", rd_word, VEC[v][31:0]);
            @(negedge rd_clk); rd_req = 1;
            @(negedge rd_clk); rd_req = 0;
            chk("R2 empty after read", 32'(rd_empty), 1);
        end
        wr_idle(5);
        chk("R7 wr_used drained", 32'(wr_used), 0);

        // R5 fill to capacity, R3 push while full
        for (int n = 0; n < 2048; n++) push(pat(n));
        wr_idle(1);
        chk("R5 wr_full", 32'(wr_full), 1);
        chk("R5 wr_used", 32'(wr_used), 2048);
        push(8'hEE);
        wr_idle(1);
        chk("R3 wr_used unchanged", 32'(wr_used), 2048);
        rd_idle(6);
        chk("R7 rd_used", 32'(rd_used), 512);
        for (int i = 0; i < 512; i++) begin
            @(negedge rd_clk);
            chk("R3 drain word",
                rd_word, {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)});
            rd_req = 1;
        end
        @(negedge rd_clk); rd_req = 0;
        chk("R3 empty after drain, no extra byte", 32'(rd_empty), 1);
        wr_idle(5);
        chk("R7 wr_used after drain", 32'(wr_used), 0);
        chk("R5 full cleared", 32'(wr_full), 0);

        // R4 read while empty
        for (int i = 0; i < 5; i++) begin
            @(negedge rd_clk); rd_req = 1;
        end
        rd_idle(1);
        chk("R4 rd_used", 32'(rd_used), 0);
        chk("R4 rd_empty", 32'(rd_empty), 1);

        // R6 partial group hidden
        push(8'h10); push(8'h20);
        wr_idle(1);
        rd_idle(6);
        chk("R6 rd_empty", 32'(rd_empty), 1);
        chk("R6 rd_used", 32'(rd_used), 0);
        chk("R7 wr_used pending", 32'(wr_used), 2);
        push(8'h30); push(8'h40);
        wr_idle(1);
        rd_idle(6);
        chk("R6 rd_used complete", 32'(rd_used), 1);
        chk("R1 late word", rd_word, 32'h40302010);
        @(negedge rd_clk); rd_req = 1;
        rd_idle(1);

        // R10 stress with reference queue
        fork
            begin
                for (int n = 0; n < NB; ) begin
                    @(negedge wr_clk);
                    if (!wr_full && $urandom_range(0, 99) < 85) begin
                        wr_req  = 1;
                        wr_byte = 8'($urandom);
                        q.push_back(wr_byte);
                        n++;
                    end else begin
                        wr_req  = wr_full;
                        wr_byte = 8'hEE;
                    end
                end
                @(negedge wr_clk); wr_req = 0;
            end
            begin
                int got = 0;
                int cyc = 0;
                int rate;
                logic [31:0] exp;
                while (got < NW) begin
                    @(negedge rd_clk);
                    cyc++;
                    rate = ((cyc % 20000) < 5000) ? 0 : 90;
                    if (rd_used > 10'd512) chk("R4 count wrap", 32'(rd_used), 512);
                    if (!rd_empty && $urandom_range(0, 99) < rate) begin
                        exp = {q[3], q[2], q[1], q[0]};
                        repeat (4) void'(q.pop_front());
                        chk("R10 stream word", rd_word, exp);
                        rd_req = 1;
                        got++;
                    end else begin
                        rd_req = rd_empty && ($urandom_range(0, 99) < 20);
                    end
                end
                @(negedge rd_clk); rd_req = 0;
            end
        join
        rd_idle(6);
        chk("R10 all read", 32'(rd_empty), 1);
        chk("R10 queue empty", 32'(q.size()), 0);
        finish_run();
    end
endmodule